// File: doc/BRIEF.md
# Copy-Verify Controller with Retry

This block steps through every byte of a source memory and writes it into a one-time-programmable target. An external phase clock divides each byte into two halves. While the phase is high, the source is read and the target is programmed. While the phase is low, the target reads the byte back and the source rests. When the program half begins, the controller captures the source byte from the shared data bus into a holding register. In the same clock cycle it starts an active-low programming pulse, whose width is counted in system clock cycles from a loadable register. When the verify half begins, it compares the read-back with the held byte.

A failed verify locks the address and the byte is written again on the next phase cycle. After the third failed verify at one address, the lock is released and the address moves on anyway. A successful verify clears the retry count and advances the address. After the last address has been verified, or has used up its retries, the controller stops issuing pulses and raises a done flag.

The phase input is sampled in the system clock domain, and every decision is taken on an edge of the phase as seen by that domain. The address counter is `BASE_W` bits wide, and a wide-mode input adds one more address bit for a device twice as large. `start_i` begins a pass when no pass is running.

Top module: `copy_verify_ctrl`

## Requirements
- R1: After reset `addr_o` is 0, `pgm_pulse_no` is 1, and `mismatch_o`, `lock_o`, `done_o`, `src_rd_o`, `tgt_pgm_o` and `tgt_vfy_o` are all 0.
- R2: While a pass runs, `src_rd_o` and `tgt_pgm_o` are 1 and `tgt_vfy_o` is 0 during the high phase. During the low phase `tgt_vfy_o` is 1 and the other two are 0.
- R3: At each program-phase start during a pass, `pgm_pulse_no` goes low for exactly the loaded width in system clock cycles. The width is loaded through `width_we_i`/`width_i` and resets to `DEF_WIDTH`. A width of 0 gives no pulse.
- R4: A pulse still low when the verify phase starts is ended in the same clock cycle that the phase drop is seen, so no pulse overlaps the verify phase.
- R5: The byte on `data_i` is captured when the program phase starts. Later bus changes during that program phase do not change the compare result.
- R6: The compare happens only when the verify phase starts. `mismatch_o` holds its result (1 = differed) until the next verify. A match advances `addr_o` by one.
- R7: A mismatch that is not the third in a row at one address sets `lock_o` and leaves `addr_o` unchanged.
- R8: The third consecutive mismatch at one address clears `lock_o`, advances the address and clears the retry count.
- R9: A successful verify clears the retry count, so two mismatches at the next address still leave it locked.
- R10: After the last address passes or uses up its retries, `done_o` goes to 1, `addr_o` holds, and no further pulses are issued.
- R11: The last address is 2^BASE_W-1 (0x7FFF by default) when `wide_i` is 0, and 2^(BASE_W+1)-1 (0xFFFF by default) when `wide_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass from address 0 (ignored while running) |
| wide_i | input | 1 | Use one extra address bit |
| width_we_i | input | 1 | Load the pulse width |
| width_i | input | PW_W | Pulse width in clock cycles |
| phase_i | input | 1 | Phase clock: 1 = program half, 0 = verify half |
| data_i | input | 8 | Shared data bus |
| addr_o | output | ADDR_W | Current address |
| src_rd_o | output | 1 | Source in read mode |
| tgt_pgm_o | output | 1 | Target in program mode |
| tgt_vfy_o | output | 1 | Target in verify mode |
| pgm_pulse_no | output | 1 | Programming pulse, active low |
| mismatch_o | output | 1 | Result of the last verify |
| lock_o | output | 1 | Address frozen for a retry |
| done_o | output | 1 | Pass finished |

## Verification
The bench changes `phase_i` and `data_i` on the falling clock edge. The rising clock edge that follows registers the phase change, so the mode outputs, the pulse start or cut, and the verify result (mismatch, lock and address) are all due one cycle after the phase change. The bench samples each of them on the next falling edge. The pulse is counted over the falling-edge samples of the program half, so a width of W yields W low samples, and a cut pulse yields as many low samples as the half lasts. The bench shrinks `BASE_W` to 4 so that the end of the address space and wide mode are reached within a short run.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} cvc_state_e;
  localparam int unsigned RETRY_MAX = 3;
endpackage

// File: rtl/cvc_pulse_gen.sv
module cvc_pulse_gen #(
  parameter int unsigned PW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            phase_i,
  input  logic [PW_W-1:0] width_i,
  output logic            active_o
);
  logic [PW_W-1:0] cnt_q;
  logic            act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (fire_i) begin
      cnt_q <= width_i - 1'b1;
      act_q <= (width_i != '0);
    end else if (act_q) begin
      // cut at verify start or when the count runs out
      if (!phase_i || cnt_q == '0) act_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/cvc_retry.sv
module cvc_retry #(
  parameter int unsigned RETRY_MAX = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic verify_i,
  input  logic match_i,
  output logic advance_o,
  output logic lock_o,
  output logic mismatch_o
);
  localparam int unsigned CW = (RETRY_MAX > 2) ? $clog2(RETRY_MAX) : 1;
  localparam logic [CW-1:0] LAST_TRY = CW'(RETRY_MAX - 1);

  logic [CW-1:0] cnt_q;
  logic          lock_q, mis_q, exhausted;

  assign exhausted = (cnt_q == LAST_TRY);
  assign advance_o = verify_i && (match_i || exhausted);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      mis_q  <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      mis_q  <= 1'b0;
    end else if (verify_i) begin
      mis_q <= !match_i;
      if (match_i || exhausted) begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        lock_q <= 1'b1;
      end
    end
  end

  assign lock_o     = lock_q;
  assign mismatch_o = mis_q;
endmodule

// File: rtl/cvc_addr_ctr.sv
module cvc_addr_ctr #(
  parameter int unsigned BASE_W = 15,
  parameter int unsigned ADDR_W = BASE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_NARROW = ADDR_W'((1 << BASE_W) - 1);
  localparam logic [ADDR_W-1:0] LAST_WIDE   = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clear_i) addr_q <= '0;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign last_o = (addr_q == (wide_i ? LAST_WIDE : LAST_NARROW));
  assign addr_o = addr_q;
endmodule

// File: rtl/copy_verify_ctrl.sv
module copy_verify_ctrl
  import cvc_pkg::*;
#(
  parameter int unsigned BASE_W    = 15,
  parameter int unsigned ADDR_W    = BASE_W + 1,
  parameter int unsigned PW_W      = 16,
  parameter int unsigned DEF_WIDTH = 19500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic              width_we_i,
  input  logic [PW_W-1:0]   width_i,
  input  logic              phase_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              src_rd_o,
  output logic              tgt_pgm_o,
  output logic              tgt_vfy_o,
  output logic              pgm_pulse_no,
  output logic              mismatch_o,
  output logic              lock_o,
  output logic              done_o
);
  cvc_state_e      state_q;
  logic            phase_q, armed_q, run, rise, fall, fire, verify, match;
  logic            go, advance, at_last, pulse_act;
  logic [7:0]      hold_q;
  logic [PW_W-1:0] width_q;

  assign run    = (state_q == ST_RUN);
  assign go     = start_i && !run;
  assign rise   = phase_i && !phase_q;
  assign fall   = !phase_i && phase_q;
  assign fire   = run && rise;
  assign verify = run && fall && armed_q;
  assign match  = (data_i == hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      armed_q <= 1'b0;
      hold_q  <= '0;
      width_q <= PW_W'(DEF_WIDTH);
    end else begin
      phase_q <= phase_i;
      if (width_we_i) width_q <= width_i;
      if (fire) hold_q <= data_i;
      if (go || verify) armed_q <= 1'b0;
      else if (fire)    armed_q <= 1'b1;
      if (go) state_q <= ST_RUN;
      else if (advance && at_last) state_q <= ST_DONE;
    end
  end

  cvc_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk_i, .rst_ni, .fire_i(fire), .phase_i, .width_i(width_q), .active_o(pulse_act)
  );

  cvc_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk_i, .rst_ni, .clear_i(go), .verify_i(verify), .match_i(match),
    .advance_o(advance), .lock_o, .mismatch_o
  );

  cvc_addr_ctr #(.BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .clear_i(go), .inc_i(advance && !at_last), .wide_i,
    .addr_o, .last_o(at_last)
  );

  assign src_rd_o     = run && phase_q;
  assign tgt_pgm_o    = run && phase_q;
  assign tgt_vfy_o    = run && !phase_q;
  assign pgm_pulse_no = !pulse_act;
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/cvc_chk.sv
module cvc_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic              tgt_pgm_o,
  input logic              tgt_vfy_o,
  input logic              pgm_pulse_no,
  input logic              mismatch_o,
  input logic              lock_o,
  input logic              done_o
);
  // R4
  pulse_in_pgm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_pulse_no |-> (tgt_pgm_o && !tgt_vfy_o));
  // R10
  done_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pgm_pulse_no);
  // R7
  lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $stable(addr_o));
  // R6
  mismatch_at_verify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mismatch_o) |-> tgt_vfy_o);
  // R8
  done_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_o);
endmodule

bind copy_verify_ctrl cvc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_o(addr_o), .tgt_pgm_o(tgt_pgm_o),
  .tgt_vfy_o(tgt_vfy_o), .pgm_pulse_no(pgm_pulse_no), .mismatch_o(mismatch_o),
  .lock_o(lock_o), .done_o(done_o)
);

// File: tb/copy_verify_ctrl_tb.sv
`timescale 1ns/1ps
module copy_verify_ctrl_tb;
  localparam int BASE_W = 4;
  localparam int ADDR_W = 5;
  localparam int PW_W   = 8;
  localparam int H      = 10;

  logic clk = 0, rst_ni = 0, start = 0, wide = 0, width_we = 0, phase = 0;
  logic [PW_W-1:0] width = '0;
  logic [7:0] data = '0;
  logic [ADDR_W-1:0] addr;
  logic src_rd, tgt_pgm, tgt_vfy, pulse_n, mis, lock, done;
  int checks = 0, fails = 0, cyc = 0;
  logic s_src, s_pgm, s_vfy, post;
  int lows;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  copy_verify_ctrl #(.BASE_W(BASE_W), .ADDR_W(ADDR_W), .PW_W(PW_W), .DEF_WIDTH(6)) u_dut (
    .clk_i(clk), .rst_ni, .start_i(start), .wide_i(wide), .width_we_i(width_we),
    .width_i(width), .phase_i(phase), .data_i(data), .addr_o(addr), .src_rd_o(src_rd),
    .tgt_pgm_o(tgt_pgm), .tgt_vfy_o(tgt_vfy), .pgm_pulse_no(pulse_n),
    .mismatch_o(mis), .lock_o(lock), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic phase_cycle(input logic [7:0] src, mid, tgt);
    lows = 0;
    @(negedge clk); phase = 1; data = src;
    for (int k = 1; k <= H; k++) begin
      @(negedge clk);
      if (!pulse_n) lows++;
      if (k == 2) begin s_src = src_rd; s_pgm = tgt_pgm; end
      if (k == H/2) data = mid;
    end
    phase = 0; data = tgt;
    @(negedge clk); post = pulse_n; s_vfy = tgt_vfy;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_start(input logic w);
    @(negedge clk); wide = w; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic load_width(input int w);
    @(negedge clk); width_we = 1; width = PW_W'(w);
    @(negedge clk); width_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr, 0);       chk("R1 pulse_n", pulse_n, 1);
    chk("R1 mismatch", mis, 0);    chk("R1 lock", lock, 0);
    chk("R1 done", done, 0);       chk("R1 modes", {src_rd, tgt_pgm, tgt_vfy}, 0);
  endtask

  task automatic t_good;
    do_start(0);
    phase_cycle(8'h5A, 8'h5A, 8'h5A);
    chk("R2 src_rd high", s_src, 1); chk("R2 tgt_pgm high", s_pgm, 1);
    chk("R2 tgt_vfy low", s_vfy, 1);
    chk("R3 default width", lows, 6);
    chk("R6 match no mismatch", mis, 0); chk("R6 advance", addr, 1);
  endtask

  task automatic t_width;
    load_width(4);
    phase_cycle(8'h21, 8'h21, 8'h21);
    chk("R3 loaded width", lows, 4); chk("R6 advance", addr, 2);
    load_width(20);
    phase_cycle(8'h22, 8'h22, 8'h22);
    chk("R4 truncated width", lows, H); chk("R4 pulse off at verify", post, 1);
    load_width(0);
    phase_cycle(8'h23, 8'h23, 8'h23);
    chk("R3 zero width", lows, 0); chk("R6 advance", addr, 4);
    load_width(3);
  endtask

  task automatic t_latch;
    phase_cycle(8'h11, 8'hEE, 8'h11);
    chk("R5 held byte matched", mis, 0); chk("R5 advance", addr, 5);
    phase_cycle(8'h12, 8'h99, 8'h99);
    chk("R5 late bus ignored", mis, 1); chk("R7 lock", lock, 1);
    phase_cycle(8'h12, 8'h12, 8'h12);
    chk("R9 match clears", lock, 0); chk("R6 addr", addr, 6);
  endtask

  task automatic t_retry;
    phase_cycle(8'h44, 8'h44, 8'h40);
    chk("R7 lock 1st", lock, 1); chk("R7 addr held", addr, 6); chk("R6 mismatch", mis, 1);
    phase_cycle(8'h44, 8'h44, 8'h41);
    chk("R9 lock 2nd", lock, 1); chk("R7 addr held", addr, 6);
    phase_cycle(8'h44, 8'h44, 8'h00);
    chk("R8 lock released", lock, 0); chk("R8 advance", addr, 7); chk("R8 mismatch", mis, 1);
    phase_cycle(8'h55, 8'h55, 8'h50);
    chk("R8 retry cleared", lock, 1); chk("R8 addr", addr, 7);
    phase_cycle(8'h55, 8'h55, 8'h55);
    chk("R6 addr", addr, 8);
  endtask

  task automatic t_done;
    for (int a = 8; a < 15; a++) phase_cycle(8'(a), 8'(a), 8'(a));
    chk("R11 last narrow addr", addr, 15); chk("R10 not done", done, 0);
    phase_cycle(8'h77, 8'h77, 8'h70);
    chk("R10 locked at last", lock, 1); chk("R10 not done", done, 0);
    phase_cycle(8'h77, 8'h77, 8'h71);
    phase_cycle(8'h77, 8'h77, 8'h72);
    chk("R10 done after retries", done, 1); chk("R10 addr holds", addr, 15);
    chk("R10 unlocked", lock, 0);
    phase_cycle(8'h01, 8'h01, 8'h01);
    chk("R10 no pulse", lows, 0); chk("R10 addr stable", addr, 15); chk("R10 done", done, 1);
  endtask

  task automatic t_wide;
    do_start(1);
    chk("R1 restart addr", addr, 0); chk("R10 done cleared", done, 0);
    for (int a = 0; a < 16; a++) phase_cycle(8'(a), 8'(a), 8'(a));
    chk("R11 wide passes narrow end", addr, 16); chk("R11 not done", done, 0);
    for (int a = 16; a < 32; a++) phase_cycle(8'(a), 8'(a), 8'(a));
    chk("R11 wide last", addr, 31); chk("R11 wide done", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1;
    @(negedge clk);
    t_good; t_width; t_latch; t_retry; t_done; t_wide;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule